// File: doc/BRIEF.md
# Reload Down-Counter Timer with Selectable Count Source

This block is a 16-bit down-counting timer that sits on a simple byte-wide register port of a microcontroller peripheral bus. Software fills a 16-bit reload value, loads the counter from it, and turns the timer on through an 8-bit control register. That register also picks the count source, the prescaler ratio, and whether the timer reloads and keeps running or stops after one pass.

The counter takes one step down for each tick of the selected source. There are four sources:
- the system clock divided by 4, 16, 64 or 256;
- rising edges of a real-time-clock tick input;
- falling edges of an external event input;
- rising edges of that same event input.

The two asynchronous inputs pass through a two-flop synchronizer and an edge detector. Each edge they produce becomes a one-cycle strobe. When the count runs out, a sticky flag is set and drives the interrupt pin. A read of the status register clears the flag. If a control bit is set, an asserted debug-break input freezes the counter and the prescaler.

The register port is plain control access, not a stream. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr` while `reg_rd` is high. There is no back-pressure: every access completes in one cycle.

Top module: `rtmr_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. The register addresses are: 0 control, 1 reload low byte, 2 reload high byte, 3 count low byte, 4 count high byte, 5 status (bit 0 = end-of-count flag). Unused addresses read 0.
- R2: The control register reads back what was written, except bit 1, which always reads 0. The control layout is: bit 0 enable, bit 1 reload-and-restart, bits [3:2] divide select, bit 4 continuous, bits [6:5] source, bit 7 break-freeze. The two reload bytes read back what was written.
- R3: Writing the control register with bit 1 set loads the counter from the reload register at that clock edge, whether or not the timer is enabled.
- R4: With source 00, the counter decrements once every N clock cycles. N is 4, 16, 64 or 256 for divide select 0, 1, 2 or 3. The prescaler restarts when the timer is enabled from the disabled state or restarted, so the first decrement comes exactly N cycles after the enabling write.
- R5: With source 01, each rising edge of `rtc_tick` decrements the counter once, and `evt_in` is ignored.
- R6: Source 10 counts only falling edges of `evt_in`, and source 11 counts only rising edges of `evt_in`.
- R7: A tick that arrives while the count is 1 or 0 is the end of count. It sets the sticky flag, and `irq` follows the flag. A read of the status register clears the flag, unless a new end of count occurs in the same cycle.
- R8: In continuous mode (bit 4 = 1), an end of count loads the counter from the reload register, and counting continues.
- R9: In single-pass mode (bit 4 = 0), an end of count leaves the counter at 0 and clears the enable bit.
- R10: With break-freeze set and `dbg_break` high, the counter and prescaler hold and source ticks are dropped. With break-freeze clear, `dbg_break` has no effect.
- R11: While the enable bit is 0, the counter does not change except through a restart write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the flag) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high |
| rtc_tick | input | 1 | Asynchronous real-time-clock tick |
| evt_in | input | 1 | Asynchronous external event input |
| dbg_break | input | 1 | Debug-break request |
| irq | output | 1 | End-of-count interrupt (the sticky flag) |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit data port and a two-stage synchronizer. Because the prescaler can be set as low as divide-by-4 and reload values can be small, the end-of-count events for both continuous and single-pass operation occur within a few dozen cycles. This lets the bench check every step of the count at an exact cycle. Divide-by-16 and divide-by-256 are also run, to confirm that the first interval has full length at the larger ratios. The event and RTC sources are driven by slow edges, so each edge can be seen to pass through the synchronizer, or to be dropped, before the next edge arrives.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
  localparam int PRE_W = 8;

  localparam logic [2:0] A_CTL    = 3'd0;
  localparam logic [2:0] A_RLD_LO = 3'd1;
  localparam logic [2:0] A_RLD_HI = 3'd2;
  localparam logic [2:0] A_CNT_LO = 3'd3;
  localparam logic [2:0] A_CNT_HI = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;

  typedef enum logic [1:0] {
    SRC_PRESCALE = 2'b00,
    SRC_RTC      = 2'b01,
    SRC_EV_FALL  = 2'b10,
    SRC_EV_RISE  = 2'b11
  } src_e;

  typedef struct packed {
    logic       brk;
    src_e       src;
    logic       cont;
    logic [1:0] div;
    logic       restart;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/rtmr_edge.sv
`timescale 1ns/1ps
module rtmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/rtmr_prescaler.sv
`timescale 1ns/1ps
module rtmr_prescaler
  import rtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    unique case (div_sel)
      2'd0:    limit = PRE_W'(3);
      2'd1:    limit = PRE_W'(15);
      2'd2:    limit = PRE_W'(63);
      default: limit = PRE_W'(255);
    endcase
  end

  assign tick = run & ~clr & (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtmr_count.sv
`timescale 1ns/1ps
module rtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cont,
  output logic [CNT_W-1:0] count,
  output logic             eoc
);
  logic [CNT_W-1:0] count_q;

  assign eoc   = run & tick & ~load & (count_q <= CNT_W'(1));
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (load)           count_q <= load_val;
    else if (eoc)            count_q <= cont ? load_val : '0;
    else if (run && tick)    count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/rtmr_top.sv
`timescale 1ns/1ps
module rtmr_top
  import rtmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rtc_tick,
  input  logic              evt_in,
  input  logic              dbg_break,
  output logic              irq
);
  localparam int EXT_W = 2 * DATA_W;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             eoc;

  logic ctl_wr, restart, pre_clr, freeze, run;
  logic pre_tick, rtc_rise, rtc_fall, ev_rise, ev_fall, src_tick;
  logic [EXT_W-1:0] rld_ext, cnt_ext;

  assign ctl_wr  = reg_wr && (reg_addr == A_CTL);
  assign restart = ctl_wr && reg_wdata[1];
  assign pre_clr = restart || (ctl_wr && reg_wdata[0] && !ctl_q.en);
  assign freeze  = ctl_q.brk & dbg_break;
  assign run     = ctl_q.en & ~freeze;

  rtmr_edge #(.STAGES(SYNC_ST)) u_rtc_edge (
    .clk(clk), .rst_n(rst_n), .din(rtc_tick), .rise(rtc_rise), .fall(rtc_fall)
  );
  rtmr_edge #(.STAGES(SYNC_ST)) u_evt_edge (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .rise(ev_rise), .fall(ev_fall)
  );

  rtmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n),
    .run(run && (ctl_q.src == SRC_PRESCALE)),
    .clr(pre_clr), .div_sel(ctl_q.div), .tick(pre_tick)
  );

  always_comb begin
    unique case (ctl_q.src)
      SRC_PRESCALE: src_tick = pre_tick;
      SRC_RTC:      src_tick = rtc_rise;
      SRC_EV_FALL:  src_tick = ev_fall;
      default:      src_tick = ev_rise;
    endcase
  end

  rtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(src_tick),
    .load(restart), .load_val(reload_q), .cont(ctl_q.cont),
    .count(count_q), .eoc(eoc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q         <= ctl_t'(reg_wdata);
      ctl_q.restart <= 1'b0;
    end else if (eoc && !ctl_q.cont) begin
      ctl_q.en <= 1'b0;
    end
  end

  assign rld_ext = EXT_W'(reload_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reg_wr && reg_addr == A_RLD_LO) begin
      reload_q <= CNT_W'({rld_ext[EXT_W-1:DATA_W], reg_wdata});
    end else if (reg_wr && reg_addr == A_RLD_HI) begin
      reload_q <= CNT_W'({reg_wdata, rld_ext[DATA_W-1:0]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             flag_q <= 1'b0;
    else if (eoc)                           flag_q <= 1'b1;
    else if (reg_rd && reg_addr == A_STAT)  flag_q <= 1'b0;
  end

  assign irq     = flag_q;
  assign cnt_ext = EXT_W'(count_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_CTL:    reg_rdata = DATA_W'(ctl_q);
        A_RLD_LO: reg_rdata = rld_ext[DATA_W-1:0];
        A_RLD_HI: reg_rdata = rld_ext[EXT_W-1:DATA_W];
        A_CNT_LO: reg_rdata = cnt_ext[DATA_W-1:0];
        A_CNT_HI: reg_rdata = cnt_ext[EXT_W-1:DATA_W];
        A_STAT:   reg_rdata = DATA_W'(flag_q);
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtmr_checker.sv
`timescale 1ns/1ps
module rtmr_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dbg_break,
  input logic              irq,
  input logic [7:0]        ctl_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              eoc
);
  logic ctl_write;
  assign ctl_write = reg_wr && (reg_addr == 3'd0);

  a_r3_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && reg_wdata[1]) |=> (count_q == $past(reload_q)));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> irq);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5 && !eoc) |=> !irq);

  a_r8_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && ctl_q[4]) |=> (count_q == $past(reload_q)));

  a_r9_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !ctl_q[4] && !ctl_write) |=> (count_q == '0 && !ctl_q[0]));

  a_r10_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7] && dbg_break && !ctl_write) |=> $stable(count_q));

  a_r11_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && !ctl_write) |=> $stable(count_q));
endmodule

bind rtmr_top rtmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .dbg_break(dbg_break),
  .irq(irq), .ctl_q(ctl_q), .count_q(count_q), .reload_q(reload_q), .eoc(eoc)
);

// File: tb/tb_rtmr_top.sv
`timescale 1ns/1ps
module tb_rtmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rtc_tick = 1'b0, evt_in = 1'b0, dbg_break = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtmr_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rtc_tick(rtc_tick), .evt_in(evt_in), .dbg_break(dbg_break), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), exp);
  endtask

  task automatic set_reload(input logic [15:0] v);
    wr(3'd1, v[7:0]);
    wr(3'd2, v[15:8]);
  endtask

  task automatic evt_set(input logic v);
    evt_in = v; wait_cyc(4);
  endtask

  task automatic rtc_set(input logic v);
    rtc_tick = v; wait_cyc(4);
  endtask

  task automatic test_reset;
    chk("R1 irq after reset", int'(irq), 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 register after reset", 3'(a), 0);
  endtask

  task automatic test_readback;
    set_reload(16'h1234);
    rd_chk("R2 reload low", 3'd1, 8'h34);
    rd_chk("R2 reload high", 3'd2, 8'h12);
    wr(3'd0, 8'hFE);
    rd_chk("R2 ctl bit1 reads 0", 3'd0, 8'hFC);
    rd_chk("R3 count low after restart", 3'd3, 8'h34);
    rd_chk("R3 count high after restart", 3'd4, 8'h12);
    wr(3'd0, 8'h00);
  endtask

  task automatic test_prescale(input int sel, input int n);
    set_reload(16'd10);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'(8'h11 | (sel << 2)));
    wait_cyc(n - 1);
    rd_chk("R4 count before first interval", 3'd3, 10);
    rd_chk("R4 count after first interval", 3'd3, 9);
    wait_cyc(n - 2);
    rd_chk("R4 count before second interval", 3'd3, 9);
    rd_chk("R4 count after second interval", 3'd3, 8);
    wr(3'd0, 8'h00);
  endtask

  task automatic test_continuous;
    set_reload(16'd3);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h11);
    wait_cyc(11);
    chk("R7 irq low before end", int'(irq), 0);
    wait_cyc(1);
    chk("R7 irq high at end", int'(irq), 1);
    rd_chk("R7 status flag set", 3'd5, 1);
    rd_chk("R8 reloaded count", 3'd3, 3);
    rd_chk("R7 flag cleared by read", 3'd5, 0);
    chk("R7 irq low after read", int'(irq), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic test_single;
    set_reload(16'd2);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h01);
    wait_cyc(8);
    rd_chk("R9 enable cleared", 3'd0, 0);
    rd_chk("R9 count stops at 0", 3'd3, 0);
    rd_chk("R7 flag set single pass", 3'd5, 1);
    wait_cyc(8);
    rd_chk("R11 count held while disabled", 3'd3, 0);
  endtask

  task automatic test_events;
    set_reload(16'd5);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h61);
    evt_set(1'b1);
    rd_chk("R6 rising edge counted", 3'd3, 4);
    evt_set(1'b0);
    rd_chk("R6 falling edge ignored in rising mode", 3'd3, 4);
    wr(3'd0, 8'h41);
    evt_set(1'b1);
    rd_chk("R6 rising edge ignored in falling mode", 3'd3, 4);
    evt_set(1'b0);
    rd_chk("R6 falling edge counted", 3'd3, 3);
    wr(3'd0, 8'h60);
    evt_set(1'b1); evt_set(1'b0);
    rd_chk("R11 event ignored while disabled", 3'd3, 3);
  endtask

  task automatic test_rtc;
    set_reload(16'd7);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h21);
    rtc_set(1'b1);
    rd_chk("R5 rtc rising edge counted", 3'd3, 6);
    rtc_set(1'b0);
    rd_chk("R5 rtc falling edge ignored", 3'd3, 6);
    evt_set(1'b1); evt_set(1'b0);
    rd_chk("R5 event input ignored in rtc mode", 3'd3, 6);
  endtask

  task automatic test_break;
    wr(3'd0, 8'hA1);
    dbg_break = 1'b1;
    rtc_set(1'b1);
    rd_chk("R10 frozen count holds", 3'd3, 6);
    rtc_set(1'b0);
    dbg_break = 1'b0;
    rtc_set(1'b1); rtc_set(1'b0);
    rd_chk("R10 counts after break released", 3'd3, 5);
    wr(3'd0, 8'h21);
    dbg_break = 1'b1;
    rtc_set(1'b1); rtc_set(1'b0);
    rd_chk("R10 break ignored when freeze off", 3'd3, 4);
    dbg_break = 1'b0;
    wr(3'd0, 8'h00);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    test_reset();
    test_readback();
    test_prescale(0, 4);
    test_prescale(1, 16);
    test_prescale(3, 256);
    test_continuous();
    test_single();
    test_events();
    test_rtc();
    test_break();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule